// File: doc/BRIEF.md
# I2C Counted Read Sequencer

This block runs the receive side of an I2C master read. Software arms it with one control word that holds a byte count and a flag. The flag says whether the final byte of the read is answered with NAK. While armed, the sequencer asks an external bit engine for one byte at a time and tells it which acknowledge level to drive in the ninth clock. It stores each received byte in a 64-entry receive FIFO, and it raises a sticky read-complete status once the count runs out.

A long read is split into chunks of at most 64 bytes. Software arms every chunk with the flag clear except the last one, which has the flag set, so the slave sees ACK on every byte but the very last. Software drains the FIFO one byte per pop. A pop on an empty FIFO returns zero. Address phases and START/STOP generation belong to other logic.

Top module: `rx_count_seq`

## Requirements
- R1: A write of the control word while `busy` is low, with a non-zero count, sets `busy` and clears `done` at the next clock edge. While `busy` is high and the FIFO holds fewer than 64 bytes, `rx_req` is high.
- R2: The count is taken from control bits [6:0], and any value above 64 is treated as 64. Exactly that many byte handshakes (`rx_done` while `rx_req` is high) are accepted. After the last one, `busy` and `rx_req` are low.
- R3: Control bit 7 is the NAK flag. `rx_nak` is high during the final byte of a read armed with bit 7 set, and low (ACK) for every other byte and for every byte of a read armed with bit 7 clear.
- R4: `done` goes high one edge after the final byte handshake and stays high until the next accepted control write. `irq` equals `done` AND `irq_en`.
- R5: An accepted control write with count zero sets `done` at the next edge, and `busy` and `rx_req` never rise.
- R6: A control write while `busy` is high is ignored: the remaining count and the NAK flag keep their values.
- R7: Each `pop` returns the oldest stored byte on `pop_data` one edge later. `rx_empty` is high exactly when no byte is stored.
- R8: A `pop` while `rx_empty` is high makes `pop_data` zero and leaves the FIFO contents and order unchanged.
- R9: When the FIFO holds 64 bytes, `rx_req` is low and the read stalls with `busy` high. It resumes once a pop frees an entry, and no byte is ever lost.
- R10: A pulse on `rx_done` while `rx_req` is low stores nothing and changes no count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_word | input | 8 | Bits [6:0] byte count, bit 7 NAK-on-last flag |
| irq_en | input | 1 | Interrupt enable for read-complete |
| rx_req | output | 1 | Request to the bit engine for one more byte |
| rx_nak | output | 1 | Acknowledge level for the current byte: 1 = NAK, 0 = ACK |
| rx_done | input | 1 | Bit engine pulse: a byte has been received |
| rx_byte | input | 8 | Received byte, valid with `rx_done` |
| pop | input | 1 | Read-out strobe for the receive FIFO |
| pop_data | output | 8 | Byte returned by the latest pop (zero if the FIFO was empty) |
| rx_empty | output | 1 | Receive FIFO holds no byte |
| busy | output | 1 | A counted read is in progress |
| done | output | 1 | Sticky read-complete status |
| irq | output | 1 | Read-complete interrupt |

## Verification
A control write sampled at one edge shows on `busy`, `done` and `rx_req` after that same edge. A final byte handshake shows on `done` and `busy` one edge later, `irq` follows `done` in the same cycle, and a pop shows on `pop_data` one edge after it is sampled. `rx_empty` and the stall on `rx_req` move one edge after the push or pop that changes the fill level. The bench drives every input on the falling edge and samples on the next falling edge, so each result is read exactly one edge after its cause. The acknowledge level is checked while the byte is pending, before the handshake. A table of armed words walks counts of 1, 5, 16, 64 and a clamped 127, with and without the flag. Directed cases then cover a zero count, a write while busy, a stray handshake, a pop on an empty FIFO and a stall on a full FIFO.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  // Control word layout: count in the low field, NAK flag above it.
  localparam int CTL_W     = 8;
  localparam int CNT_FLD_W = 7;
  localparam int NAK_POS   = 7;

  typedef struct packed {
    logic                 nak_last;
    logic [CNT_FLD_W-1:0] count;
  } rd_ctl_t;
endpackage

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr;
  logic [DW-1:0] rd_q;
  logic          zero_q;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);

  // Storage without reset so it maps to block RAM.
  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr[AW-1:0]] <= din;
    if (pop && !empty) rd_q <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      zero_q <= 1'b1;
    end else begin
      if (push && !full) wr_ptr <= wr_ptr + 1'b1;
      if (pop) begin
        zero_q <= empty;
        if (!empty) rd_ptr <= rd_ptr + 1'b1;
      end
    end
  end

  assign dout = zero_q ? '0 : rd_q;

  // R9: the sequencer never offers a byte to a full FIFO.
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  // R8: a pop on an empty FIFO returns zero and moves no pointer.
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (dout == '0) && (rd_ptr == $past(rd_ptr)) && empty);
endmodule

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic             rx_done,
  input  logic             fifo_full,
  output logic             rx_req,
  output logic             rx_nak,
  output logic             push,
  output logic             busy,
  output logic             done
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  rd_ctl_t          ctl;
  logic [CNT_W-1:0] arm_cnt;
  logic [CNT_W-1:0] remain;
  logic             nak_en;
  logic             arm, take, last;

  assign ctl  = rd_ctl_t'(ctl_word);
  assign arm  = ctl_wr && !busy;
  assign last = (remain == CNT_W'(1));

  always_comb begin
    if (32'(ctl.count) > DEPTH) arm_cnt = CNT_W'(DEPTH);
    else                        arm_cnt = CNT_W'(ctl.count);
  end

  assign rx_req = busy && !fifo_full;
  assign take   = rx_done && rx_req;
  assign push   = take;
  assign rx_nak = busy && nak_en && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      remain <= '0;
      nak_en <= 1'b0;
    end else if (arm) begin
      nak_en <= ctl.nak_last;
      remain <= arm_cnt;
      if (arm_cnt == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        busy <= 1'b1;
        done <= 1'b0;
      end
    end else if (take) begin
      remain <= remain - 1'b1;
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R1: a non-zero arm starts the read and clears the old status.
  p_arm_r1: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !busy && ctl_word[CNT_FLD_W-1:0] != '0) |=> busy && !done);

  // R5: a zero count completes at once without a request.
  p_zero_count_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !busy && ctl_word[CNT_FLD_W-1:0] == '0) |=> done && !busy && !rx_req);

  // R6: writes during a read do not touch count or flag.
  p_ignore_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && busy && !take) |=> (remain == $past(remain)) && (nak_en == $past(nak_en)));

  // R4: the final handshake sets the status and ends the read.
  p_done_last_r4: assert property (@(posedge clk) disable iff (rst)
    (take && last) |=> done && !busy);

  // R3: a NAKed byte is always the closing byte of the read.
  p_nak_closes_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_nak && take) |=> !busy);

  // R10: a handshake without a request leaves the count alone.
  p_stray_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rx_req && !ctl_wr) |=> remain == $past(remain));
endmodule

// File: rtl/rx_count_seq.sv
module rx_count_seq
  import rxs_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic             irq_en,
  output logic             rx_req,
  output logic             rx_nak,
  input  logic             rx_done,
  input  logic [DW-1:0]    rx_byte,
  input  logic             pop,
  output logic [DW-1:0]    pop_data,
  output logic             rx_empty,
  output logic             busy,
  output logic             done,
  output logic             irq
);
  logic push, fifo_full;

  rxs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (ctl_wr),
    .ctl_word  (ctl_word),
    .rx_done   (rx_done),
    .fifo_full (fifo_full),
    .rx_req    (rx_req),
    .rx_nak    (rx_nak),
    .push      (push),
    .busy      (busy),
    .done      (done)
  );

  rxs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .din   (rx_byte),
    .pop   (pop),
    .dout  (pop_data),
    .empty (rx_empty),
    .full  (fifo_full)
  );

  assign irq = done && irq_en;

  // R9: a full FIFO withholds the byte request.
  p_stall_full_r9: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !rx_req);
endmodule

// File: tb/tb_rx_count_seq.sv
module tb_rx_count_seq;
  logic       clk = 1'b0;
  logic       rst;
  logic       ctl_wr;
  logic [7:0] ctl_word;
  logic       irq_en;
  logic       rx_req, rx_nak;
  logic       rx_done;
  logic [7:0] rx_byte;
  logic       pop;
  logic [7:0] pop_data;
  logic       rx_empty, busy, done, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int model_q[$];

  always #10 clk = ~clk;

  rx_count_seq dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_word(ctl_word), .irq_en(irq_en),
    .rx_req(rx_req), .rx_nak(rx_nak), .rx_done(rx_done), .rx_byte(rx_byte),
    .pop(pop), .pop_data(pop_data), .rx_empty(rx_empty), .busy(busy),
    .done(done), .irq(irq)
  );

  // word, expected byte count, expected NAK on last
  localparam int NV = 5;
  localparam logic [7:0] V_WORD [NV] = '{8'h01, 8'h85, 8'h10, 8'hC0, 8'h7F};
  localparam int         V_CNT  [NV] = '{1, 5, 16, 64, 64};
  localparam bit         V_NAK  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic arm(input logic [7:0] w);
    ctl_wr = 1'b1; ctl_word = w;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic feed(input logic [7:0] d, input bit exp_nak, input string tag);
    int guard = 0;
    while (!rx_req && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    chk({tag, " rx_req"}, rx_req, 1);
    chk({tag, " ack level"}, rx_nak, exp_nak);
    rx_done = 1'b1; rx_byte = d;
    model_q.push_back(d);
    @(negedge clk);
    rx_done = 1'b0;
  endtask

  task automatic pop_one(input string tag);
    int e;
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    e = model_q.pop_front();
    chk(tag, pop_data, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ctl_wr = 0; ctl_word = 0; irq_en = 0; rx_done = 0; rx_byte = 0; pop = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state (R1, R7)
    chk("R1 reset busy", busy, 0);
    chk("R4 reset done", done, 0);
    chk("R1 reset rx_req", rx_req, 0);
    chk("R7 reset empty", rx_empty, 1);
    chk("R8 reset pop_data", pop_data, 0);

    // Table walk (R1 R2 R3 R4 R7)
    for (int v = 0; v < NV; v++) begin
      irq_en = v[0];
      arm(V_WORD[v]);
      chk("R1 busy after arm", busy, 1);
      chk("R1 done cleared", done, 0);
      for (int i = 0; i < V_CNT[v]; i++)
        feed(8'((v * 37 + i * 11 + 3) & 8'hFF),
             (i == V_CNT[v] - 1) ? V_NAK[v] : 1'b0, "R3");
      chk("R4 done after last", done, 1);
      chk("R4 irq", irq, int'(v[0]));
      chk("R2 busy low at end", busy, 0);
      chk("R2 rx_req low at end", rx_req, 0);
      chk("R7 not empty", rx_empty, 0);
      for (int i = 0; i < V_CNT[v]; i++) pop_one("R7 order");
      chk("R7 empty after drain", rx_empty, 1);
    end

    // R5: zero count
    arm(8'h80);
    chk("R5 done", done, 1);
    chk("R5 busy", busy, 0);
    repeat (3) @(negedge clk);
    chk("R5 no request", rx_req, 0);

    // R10: stray handshake while idle
    rx_done = 1'b1; rx_byte = 8'h5A;
    @(negedge clk);
    rx_done = 1'b0;
    chk("R10 nothing stored", rx_empty, 1);

    // R8: pop on empty, then order intact
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    chk("R8 zero data", pop_data, 0);
    chk("R8 still empty", rx_empty, 1);
    arm(8'h02);
    feed(8'hA1, 0, "R8");
    feed(8'hB2, 0, "R8");
    pop_one("R8 first after empty pop");
    pop_one("R8 second after empty pop");

    // R6: write during read ignored
    arm(8'h03);
    arm(8'h81);
    chk("R6 still busy", busy, 1);
    feed(8'h11, 0, "R6");
    chk("R6 count kept", busy, 1);
    feed(8'h22, 0, "R6");
    feed(8'h33, 0, "R6");
    chk("R6 done after three", done, 1);
    for (int i = 0; i < 3; i++) pop_one("R6 data");

    // R9: stall on full FIFO
    arm(8'h03);
    for (int i = 0; i < 3; i++) feed(8'(8'h40 + i), 0, "R9");
    arm(8'h40);
    for (int i = 0; i < 61; i++) feed(8'(8'h80 + i), 0, "R9");
    repeat (4) @(negedge clk);
    chk("R9 stalled rx_req", rx_req, 0);
    chk("R9 stalled busy", busy, 1);
    for (int i = 0; i < 3; i++) begin
      pop_one("R9 pop while stalled");
      feed(8'(8'hC0 + i), 0, "R9");
    end
    chk("R9 done", done, 1);
    for (int i = 0; i < 64; i++) pop_one("R9 drain order");
    chk("R9 empty", rx_empty, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule